// File: doc/BRIEF.md
# Prescaled PWM Timer with Complementary Output

This block is a 16-bit up-counting timer that drives a pulse-width-modulated output. A power-of-two prescaler slows the count. Software sets the timer up through a byte-wide write port. It can preload the running count, set a compare threshold and a reload limit, and write a control byte. The control byte holds the run enable, the dual-output select, the output polarity and the prescale exponent.

Each period, the count climbs from one up to the reload limit and then starts again at one. In each period the output spends the part of the period above the compare threshold at one level and the rest at the other level; the polarity bit selects which part is high. In dual mode a second pin stops acting as an input and carries the inverse of the main output. A single-cycle interrupt pulse marks every reload. A count preloaded by software sets the length of the first period only.

Top module: `pwm_timer`

## Requirements
- R1: After reset the count is 1, the compare value is 0, the reload value is FFFFh and the control byte is 0. With these values `pwm_o`, `pwm_aux_o`, `pwm_aux_oe_o` and `irq_o` are all 0.
- R2: Write addresses are: 0 count high byte, 1 count low byte, 2 compare high, 3 compare low, 4 reload high, 5 reload low, 6 control. Writes to address 7 are ignored. In the control byte, bit 7 is run, bit 6 is dual, bit 5 is polarity and bits 2:0 are the prescale exponent n. While running, the count advances once every 2^n clocks, so one full period lasts reload × 2^n clocks.
- R3: With polarity 0 and compare < reload, `pwm_o` is high while count > compare. That gives (reload − compare) × 2^n high clocks per period.
- R4: With polarity 1, `pwm_o` is high while count ≤ compare. That gives compare × 2^n high clocks per period.
- R5: With dual = 1, `pwm_aux_oe_o` is 1 and `pwm_aux_o` is the inverse of `pwm_o`. With dual = 0, both of these outputs are 0.
- R6: With run = 0 the count holds its value, no interrupt is raised, and `pwm_o` equals the polarity bit, which is its inactive level.
- R7: On the clock edge where an advance finds the count equal to reload, `irq_o` goes high for exactly one cycle. The pulse lasts one cycle whenever reload ≥ 2 or n ≥ 1.
- R8: After a reload the count is 1. A count preloaded by software makes the first period run from the preloaded value up to reload, which takes reload − preload + 1 advances. Every later period is a full one.
- R9: If a count byte write falls in the same cycle as an advance, the write wins. The addressed byte takes the written value, the other byte is kept, the count does not advance and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register select |
| wr_data_i | input | 8 | Write data byte |
| count_o | output | 16 | Current timer count |
| pwm_o | output | 1 | Main PWM output |
| pwm_aux_o | output | 1 | Complementary PWM output (dual mode) |
| pwm_aux_oe_o | output | 1 | Drive enable for the shared pin; 1 selects complement output |
| irq_o | output | 1 | One-cycle pulse at each reload |

## Verification
Two functions can meet in one cycle: a software count write and the counter's own advance. The hardest case is when that advance is also the reload wrap. The bench waits until the count sits at the reload value with the prescaler passing every clock. It then drives a low-byte write so that the write lands on the same edge as the wrap. The result is judged in the next cycle. The count must hold the written byte under the old high byte and `irq_o` must stay low, and the counting that follows must match the reference model clock for clock.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

   localparam int SEL_W = 3;

   typedef enum logic [SEL_W-1:0] {
      SEL_CNT_HI = 3'd0,
      SEL_CNT_LO = 3'd1,
      SEL_CMP_HI = 3'd2,
      SEL_CMP_LO = 3'd3,
      SEL_RLD_HI = 3'd4,
      SEL_RLD_LO = 3'd5,
      SEL_CTRL   = 3'd6
   } reg_sel_e;

   typedef struct packed {
      logic run;
      logic dual;
      logic inv;
   } mode_t;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
   import pwm_timer_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PS_W   = 3
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  wr_en_i,
   input  logic [SEL_W-1:0]      wr_addr_i,
   input  logic [DATA_W-1:0]     wr_data_i,
   output logic [2*DATA_W-1:0]   cmp_o,
   output logic [2*DATA_W-1:0]   rld_o,
   output mode_t                 mode_o,
   output logic [PS_W-1:0]       exp_o,
   output logic                  cnt_wr_hi_o,
   output logic                  cnt_wr_lo_o
);
   localparam int CNT_W    = 2 * DATA_W;
   localparam int RUN_BIT  = DATA_W - 1;
   localparam int DUAL_BIT = DATA_W - 2;
   localparam int INV_BIT  = DATA_W - 3;

   logic sel_cmp_hi, sel_cmp_lo, sel_rld_hi, sel_rld_lo, sel_ctrl;

   always_comb begin
      cnt_wr_hi_o = wr_en_i && (wr_addr_i == SEL_CNT_HI);
      cnt_wr_lo_o = wr_en_i && (wr_addr_i == SEL_CNT_LO);
      sel_cmp_hi  = wr_en_i && (wr_addr_i == SEL_CMP_HI);
      sel_cmp_lo  = wr_en_i && (wr_addr_i == SEL_CMP_LO);
      sel_rld_hi  = wr_en_i && (wr_addr_i == SEL_RLD_HI);
      sel_rld_lo  = wr_en_i && (wr_addr_i == SEL_RLD_LO);
      sel_ctrl    = wr_en_i && (wr_addr_i == SEL_CTRL);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cmp_o  <= '0;
         rld_o  <= {CNT_W{1'b1}};
         mode_o <= '0;
         exp_o  <= '0;
      end else begin
         if (sel_cmp_hi) cmp_o[CNT_W-1:DATA_W] <= wr_data_i;
         if (sel_cmp_lo) cmp_o[DATA_W-1:0]     <= wr_data_i;
         if (sel_rld_hi) rld_o[CNT_W-1:DATA_W] <= wr_data_i;
         if (sel_rld_lo) rld_o[DATA_W-1:0]     <= wr_data_i;
         if (sel_ctrl) begin
            mode_o.run  <= wr_data_i[RUN_BIT];
            mode_o.dual <= wr_data_i[DUAL_BIT];
            mode_o.inv  <= wr_data_i[INV_BIT];
            exp_o       <= wr_data_i[PS_W-1:0];
         end
      end
   end
endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
   parameter int PS_W = 3
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            run_i,
   input  logic [PS_W-1:0] exp_i,
   output logic            tick_o
);
   localparam int DIV_W = (1 << PS_W) - 1;

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] mask;

   // mask holds the low exp_i bits set; the tick fires when all of them are one
   assign mask   = ~({DIV_W{1'b1}} << exp_i);
   assign tick_o = run_i && (&(div_q | ~mask));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     div_q <= '0;
      else if (run_i)  div_q <= div_q + 1'b1;
      else             div_q <= '0;
   end
endmodule

// File: rtl/pwm_count.sv
module pwm_count #(
   parameter int CNT_W = 16
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               tick_i,
   input  logic [CNT_W-1:0]   rld_i,
   input  logic               wr_hi_i,
   input  logic               wr_lo_i,
   input  logic [CNT_W/2-1:0] wr_data_i,
   output logic [CNT_W-1:0]   cnt_o,
   output logic               irq_o
);
   localparam int HALF = CNT_W / 2;
   localparam logic [CNT_W-1:0] RESTART = CNT_W'(1);

   logic wr_any, wrap;

   assign wr_any = wr_hi_i || wr_lo_i;
   assign wrap   = tick_i && !wr_any && (cnt_o == rld_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_o <= RESTART;
         irq_o <= 1'b0;
      end else begin
         irq_o <= wrap;
         if (wr_hi_i)      cnt_o <= {wr_data_i, cnt_o[HALF-1:0]};
         else if (wr_lo_i) cnt_o <= {cnt_o[CNT_W-1:HALF], wr_data_i};
         else if (wrap)    cnt_o <= RESTART;
         else if (tick_i)  cnt_o <= cnt_o + 1'b1;
      end
   end
endmodule

// File: rtl/pwm_out.sv
module pwm_out #(
   parameter int CNT_W   = 16,
   parameter bit DUAL_EN = 1'b1
) (
   input  logic             run_i,
   input  logic             dual_i,
   input  logic             inv_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] cmp_i,
   output logic             pwm_o,
   output logic             aux_o,
   output logic             aux_oe_o
);
   logic late_part;

   assign late_part = run_i && (cnt_i > cmp_i);
   assign pwm_o     = late_part ^ inv_i;

   generate
      if (DUAL_EN) begin : g_dual
         assign aux_oe_o = dual_i;
         assign aux_o    = dual_i && !pwm_o;
      end else begin : g_single
         logic unused_dual;
         assign unused_dual = dual_i;
         assign aux_oe_o    = 1'b0;
         assign aux_o       = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
   import pwm_timer_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int PS_W    = 3,
   parameter bit DUAL_EN = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                wr_en_i,
   input  logic [SEL_W-1:0]    wr_addr_i,
   input  logic [DATA_W-1:0]   wr_data_i,
   output logic [2*DATA_W-1:0] count_o,
   output logic                pwm_o,
   output logic                pwm_aux_o,
   output logic                pwm_aux_oe_o,
   output logic                irq_o
);
   localparam int CNT_W = 2 * DATA_W;

   generate
      if (PS_W < 1 || PS_W > 4) begin : g_bad_ps
         $error("pwm_timer: PS_W must lie in 1..4");
      end
      if (DATA_W < PS_W + 3) begin : g_bad_ctrl
         $error("pwm_timer: DATA_W too narrow for the control fields");
      end
   endgenerate

   logic [CNT_W-1:0] cmp_w, rld_w;
   mode_t            mode;
   logic [PS_W-1:0]  exp_w;
   logic             cnt_wr_hi_w, cnt_wr_lo_w, tick_w;

   pwm_regs #(.DATA_W(DATA_W), .PS_W(PS_W)) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
      .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .cmp_o(cmp_w), .rld_o(rld_w), .mode_o(mode), .exp_o(exp_w),
      .cnt_wr_hi_o(cnt_wr_hi_w), .cnt_wr_lo_o(cnt_wr_lo_w)
   );

   pwm_prescale #(.PS_W(PS_W)) u_ps (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(mode.run),
      .exp_i(exp_w), .tick_o(tick_w)
   );

   pwm_count #(.CNT_W(CNT_W)) u_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_w), .rld_i(rld_w),
      .wr_hi_i(cnt_wr_hi_w), .wr_lo_i(cnt_wr_lo_w), .wr_data_i(wr_data_i),
      .cnt_o(count_o), .irq_o(irq_o)
   );

   pwm_out #(.CNT_W(CNT_W), .DUAL_EN(DUAL_EN)) u_out (
      .run_i(mode.run), .dual_i(mode.dual), .inv_i(mode.inv),
      .cnt_i(count_o), .cmp_i(cmp_w),
      .pwm_o(pwm_o), .aux_o(pwm_aux_o), .aux_oe_o(pwm_aux_oe_o)
   );
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [CNT_W-1:0] count_o,
   input logic             pwm_o,
   input logic             pwm_aux_o,
   input logic             pwm_aux_oe_o,
   input logic             irq_o,
   input logic             run,
   input logic             inv,
   input logic             tick,
   input logic             cnt_wr,
   input logic [CNT_W-1:0] rld
);
   // R2
   count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick && !cnt_wr && count_o != rld) |=> (count_o - $past(count_o)) == CNT_W'(1));

   // R5
   aux_inverse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pwm_aux_oe_o |-> (pwm_aux_o == !pwm_o));

   // R5
   aux_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pwm_aux_oe_o |-> !pwm_aux_o);

   // R6
   stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run && !cnt_wr) |=> $stable(count_o));

   // R6
   stop_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run |-> (pwm_o == inv));

   // R7
   stop_noirq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run |=> !irq_o);

   // R8
   irq_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> count_o == CNT_W'(1));

   // R9
   write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_wr |=> !irq_o);
endmodule

bind pwm_timer pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .count_o(count_o), .pwm_o(pwm_o),
   .pwm_aux_o(pwm_aux_o), .pwm_aux_oe_o(pwm_aux_oe_o), .irq_o(irq_o),
   .run(mode.run), .inv(mode.inv), .tick(tick_w),
   .cnt_wr(cnt_wr_hi_w || cnt_wr_lo_w), .rld(rld_w)
);

// File: tb/pwm_timer_tb.sv
module pwm_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [15:0] count;
   logic        pwm, aux, aux_oe, irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pwm_timer dut_i (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .count_o(count), .pwm_o(pwm), .pwm_aux_o(aux),
      .pwm_aux_oe_o(aux_oe), .irq_o(irq)
   );

   // behavioural reference model
   int m_cnt, m_cmp, m_rld, m_ps, m_exp;
   bit m_run, m_dual, m_inv, m_irq, m_live;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 1; m_cmp = 0; m_rld = 16'hFFFF; m_ps = 0; m_exp = 0;
         m_run = 0; m_dual = 0; m_inv = 0; m_irq = 0; m_live = 1;
      end else begin
         int  mask;
         bit  tk, cw, wrapped;
         mask    = (1 << m_exp) - 1;
         tk      = m_run && ((m_ps & mask) == mask);
         cw      = wr_en && (wr_addr == 3'd0 || wr_addr == 3'd1);
         wrapped = tk && !cw && (m_cnt == m_rld);
         if (cw) begin
            if (wr_addr == 3'd0) m_cnt = (m_cnt & 8'hFF) | (int'(wr_data) << 8);
            else                 m_cnt = (m_cnt & 16'hFF00) | int'(wr_data);
         end else if (wrapped) m_cnt = 1;
         else if (tk)          m_cnt = (m_cnt + 1) & 16'hFFFF;
         m_ps = m_run ? ((m_ps + 1) & 127) : 0;
         if (wr_en) begin
            case (wr_addr)
               3'd2: m_cmp = (m_cmp & 8'hFF) | (int'(wr_data) << 8);
               3'd3: m_cmp = (m_cmp & 16'hFF00) | int'(wr_data);
               3'd4: m_rld = (m_rld & 8'hFF) | (int'(wr_data) << 8);
               3'd5: m_rld = (m_rld & 16'hFF00) | int'(wr_data);
               3'd6: begin
                  m_run = wr_data[7]; m_dual = wr_data[6];
                  m_inv = wr_data[5]; m_exp = int'(wr_data[2:0]);
               end
               default: ;
            endcase
         end
         m_irq = wrapped;
      end
   end

   always @(negedge clk) begin
      if (rst_n && m_live && !done) begin
         bit e_pwm;
         e_pwm = (m_run && m_cnt > m_cmp) ^ m_inv;
         n_cmp += 4;
         if (int'(count) != m_cnt) begin
            n_bad++; $display("FAIL R2/R8 count act=%0d exp=%0d", count, m_cnt);
         end
         if (pwm != e_pwm) begin
            n_bad++; $display("FAIL %s pwm act=%0b exp=%0b", m_inv ? "R4" : "R3", pwm, e_pwm);
         end
         if (aux_oe != m_dual || aux != (m_dual && !e_pwm)) begin
            n_bad++; $display("FAIL R5 aux/oe act=%0b/%0b exp=%0b/%0b", aux, aux_oe,
                              m_dual && !e_pwm, m_dual);
         end
         if (irq != m_irq) begin
            n_bad++; $display("FAIL R7 irq act=%0b exp=%0b", irq, m_irq);
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   // called at a negedge; returns at the negedge after the capturing edge
   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic [7:0] ctl(input bit r, input bit du, input bit iv, input int e);
      return {r, du, iv, 2'b00, 3'(e)};
   endfunction

   task automatic setup(input int rl, input int cp, input int pre);
      wr(3'd6, 8'h00);
      wr(3'd4, 8'(rl >> 8)); wr(3'd5, 8'(rl));
      wr(3'd2, 8'(cp >> 8)); wr(3'd3, 8'(cp));
      wr(3'd0, 8'(pre >> 8)); wr(3'd1, 8'(pre));
   endtask

   // from one irq cycle to the next: period length and pwm high cycles
   task automatic measure(output int per, output int hi);
      int guard = 0;
      while (!irq && guard < 5000) begin @(negedge clk); guard++; end
      per = 1; hi = int'(pwm);
      @(negedge clk);
      while (!irq && per < 5000) begin
         per++; hi += int'(pwm);
         @(negedge clk);
      end
   endtask

   initial begin
      int p, h, c0, seen, n, bad;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 count", int'(count), 1);
      chk("R1 pwm", int'(pwm), 0);
      chk("R1 aux", int'(aux), 0);
      chk("R1 aux_oe", int'(aux_oe), 0);
      chk("R1 irq", int'(irq), 0);

      // R2 R3: polarity 0, reload 10, compare 3, n=0
      setup(10, 3, 1);
      wr(3'd7, 8'hFF);                  // R2: unused address ignored
      wr(3'd6, ctl(1, 0, 0, 0));
      measure(p, h);
      chk("R2 period n0", p, 10);
      chk("R3 high time", h, 7);
      @(negedge clk);
      chk("R7 pulse one cycle", int'(irq), 0);

      // R2 R4: polarity 1, reload 7, compare 4, n=2
      setup(7, 4, 1);
      wr(3'd6, ctl(1, 0, 1, 2));
      measure(p, h);
      chk("R2 period n2", p, 28);
      chk("R4 high time", h, 16);

      // R5: dual mode, reload 12, compare 5, n=1
      setup(12, 5, 1);
      wr(3'd6, ctl(1, 1, 0, 1));
      bad = 0;
      for (int i = 0; i < 30; i++) begin
         if (!aux_oe || aux != !pwm) bad++;
         @(negedge clk);
      end
      chk("R5 complement", bad, 0);
      measure(p, h);
      chk("R5 dual period", p, 24);
      chk("R3 dual high", h, 14);

      // R6: stop freezes count, output at inactive level
      wr(3'd6, ctl(0, 1, 1, 0));
      c0 = int'(count); seen = 0;
      for (int i = 0; i < 20; i++) begin
         if (irq) seen++;
         @(negedge clk);
      end
      chk("R6 count frozen", int'(count), c0);
      chk("R6 pwm inactive", int'(pwm), 1);
      chk("R6 no irq", seen, 0);

      // R8: preloaded first period
      setup(10, 3, 8);
      wr(3'd6, ctl(1, 0, 0, 0));
      n = 0;
      while (!irq && n < 100) begin @(negedge clk); n++; end
      chk("R8 first period", n, 3);
      chk("R8 restart at one", int'(count), 1);
      measure(p, h);
      chk("R8 full period", p, 10);

      // R9: count write on the wrap edge
      n = 0;
      while (count != 16'd10 && n < 100) begin @(negedge clk); n++; end
      wr(3'd1, 8'd5);
      chk("R9 write wins", int'(count), 5);
      chk("R9 no irq", int'(irq), 0);
      @(negedge clk);
      chk("R9 counts on", int'(count), 6);

      repeat (5) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule